// File: doc/BRIEF.md
# Modulated NCO Phase Engine

This block is the phase generator at the front of a direct digital synthesizer. A wide phase accumulator advances on every clock by the sum of up to three frequency words: a base (carrier) word, a deviation word used for frequency-shift keying, and a word delivered by an external serial receiver. The top bits of the accumulator, shifted by a selectable quarter-turn, are delayed through a short pipeline and presented as a phase word for a downstream sine lookup.

The base and deviation words are written one byte at a time over a small parallel register bus into holding registers. They only reach the accumulator when a load takes place, requested either by a level on a load pin or by a write of any value to the load address; both words then switch over on the same edge. Three modulation pins (a deviation gate and a two-bit quadrant select) and the load pin are asynchronous to the clock and are resynchronized before use. A control register bit decides whether the serial word takes part in the sum.

Top module: `dds_phase_engine`

## Requirements
- R1: Reset is synchronous and active low; while it is applied the phase output is 0. After release the base word is 2^46 (only bit 46 set), the deviation path is gated off, the serial path is enabled, so with the serial word at 0 the output first becomes 0x4000 on the 11th rising edge after release and grows by 0x4000 per clock.
- R2: The output after rising edge k equals the top 16 bits of the accumulator as it stood after edge k-10, plus the quadrant offset then in force (a fixed pipeline).
- R3: The accumulator adds base + gated deviation + enabled serial word each clock, modulo 2^48; a base of all ones with a deviation of 1 holds the phase still.
- R4: While the synchronized deviation gate is low, the deviation word contributes zero; while it is high, the active deviation word is added.
- R5: Bit 6 of the byte written to address 13 enables (1) or removes (0) the serial word from the sum; the other bits of that byte have no effect; the bit resets to 1.
- R6: Addresses 0..5 write bytes 0..5 (least significant first) of the base holding register and addresses 6..11 the same bytes of the deviation holding register; writing a holding register does not change the output until a load.
- R7: A high synchronized load pin copies both holding registers into the active registers on the same edge, every edge it stays high.
- R8: A write of any data to address 15 performs the same load as the pin, on the edge of the write.
- R9: The quadrant select code q (00=0°, 01=90°, 10=180°, 11=270°) adds q·0x4000 modulo 2^16 to the phase output.
- R10: The load pin, deviation gate and quadrant select each pass through two flip-flops; a pin value present at edge j is acted upon at edge j+2.
- R11: A register write presented on the first rising edge after reset release is discarded; writes are taken from the second edge on.
- R12: Writes to addresses 12 and 14 change no state and have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write byte |
| load_pin | input | 1 | Asynchronous load request (level) |
| fsk_gate | input | 1 | Asynchronous deviation-word enable |
| quad_sel | input | 2 | Asynchronous quadrant phase select |
| ser_freq | input | 48 | Frequency word from the serial receiver |
| phase_word | output | 16 | Phase word for the sine lookup |

## Verification
The accumulator is first run on the reset base word alone, which separates pipeline latency from step size; then held base words of differing byte patterns are written with and without a following load, telling holding from active state. The deviation gate is toggled every few cycles and the serial word is swept in and out through the control bit with its other bits set, so each term of the sum is isolated. All four quadrant codes, the pin and register load paths, the ignored addresses, a write on the first edge after release and a wrap-around sum that freezes the phase complete the patterns.

// File: rtl/dds_pkg.sv
// Shared types for the NCO phase engine.
// Assumes: a single synchronous clock domain for all registered logic.
package dds_pkg;

    // Which register class an address on the write bus selects
    typedef enum logic [2:0] {
        REG_NONE,
        REG_BASE,
        REG_DEV,
        REG_SERCTL,
        REG_LOAD
    } reg_kind_e;

endpackage

// File: rtl/dds_pin_sync.sv
// Multi-flop synchronizer for a bundle of asynchronous control pins.
// Assumes: each bit is independent; bundle skew of one clock is acceptable.
module dds_pin_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the pins through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/dds_freq_regs.sv
// Holding and active frequency registers with byte-wide write decode.
// Assumes: ACC_W is a multiple of DW and two words fit below SER_ADDR.
// A load (pin level or write to LOAD_ADDR) copies both holding words at once.
module dds_freq_regs
    import dds_pkg::*;
#(
    parameter int ACC_W     = 48,
    parameter int DW        = 8,
    parameter int AW        = 4,
    parameter int SER_ADDR  = 13,
    parameter int LOAD_ADDR = 15,
    parameter int SER_BIT   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             load_s,
    output logic [ACC_W-1:0] base_hold,
    output logic [ACC_W-1:0] dev_hold,
    output logic [ACC_W-1:0] base_act,
    output logic [ACC_W-1:0] dev_act,
    output logic             ser_on,
    output logic             load_any
);

    localparam int NB = ACC_W / DW;
    localparam logic [ACC_W-1:0] BASE_RST = ACC_W'(1) << (ACC_W - 2);

    logic      wr_ok;
    logic      wr_go;
    reg_kind_e kind;

    // Classify the write address
    always_comb begin
        if (wr_addr < AW'(NB))
            kind = REG_BASE;
        else if (wr_addr < AW'(2 * NB))
            kind = REG_DEV;
        else if (wr_addr == AW'(SER_ADDR))
            kind = REG_SERCTL;
        else if (wr_addr == AW'(LOAD_ADDR))
            kind = REG_LOAD;
        else
            kind = REG_NONE;
    end

    assign wr_go    = wr_en && wr_ok;
    assign load_any = load_s || (wr_go && kind == REG_LOAD);

    // Block writes on the first edge after reset release
    always_ff @(posedge clk) begin
        if (!rst_n) wr_ok <= 1'b0;
        else        wr_ok <= 1'b1;
    end

    // Byte writes into the holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hold <= BASE_RST;
            dev_hold  <= '0;
        end else if (wr_go) begin
            for (int b = 0; b < NB; b++) begin
                if (kind == REG_BASE && wr_addr == AW'(b))
                    base_hold[b*DW +: DW] <= wr_data;
                if (kind == REG_DEV && wr_addr == AW'(NB + b))
                    dev_hold[b*DW +: DW] <= wr_data;
            end
        end
    end

    // Transfer both holding words to the active words together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_act <= BASE_RST;
            dev_act  <= '0;
        end else if (load_any) begin
            base_act <= base_hold;
            dev_act  <= dev_hold;
        end
    end

    // Serial word enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)                           ser_on <= 1'b1;
        else if (wr_go && kind == REG_SERCTL) ser_on <= wr_data[SER_BIT];
    end

endmodule

// File: rtl/dds_phase_acc.sv
// Phase accumulator, quadrant offset and output delay line.
// Assumes: LAT >= 2; LAT counts edges from reset release to the first
// accumulator advance appearing at the output.
module dds_phase_acc #(
    parameter int ACC_W = 48,
    parameter int OUT_W = 16,
    parameter int LAT   = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] base,
    input  logic [ACC_W-1:0] dev,
    input  logic [ACC_W-1:0] ser,
    input  logic             dev_on,
    input  logic             ser_on,
    input  logic [1:0]       quad,
    output logic [OUT_W-1:0] phase
);

    localparam int NSTG = LAT - 1;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] step;
    logic [OUT_W-1:0] head;

    // Sum of the contributing frequency words
    always_comb begin
        step = base + (dev_on ? dev : '0) + (ser_on ? ser : '0);
    end

    // Accumulate phase, wrapping modulo 2^ACC_W
    always_ff @(posedge clk) begin
        if (!rst_n) acc <= '0;
        else        acc <= acc + step;
    end

    assign head = acc[ACC_W-1 -: OUT_W] + {quad, {(OUT_W-2){1'b0}}};

    genvar g;
    generate
        for (g = 0; g < NSTG; g++) begin : g_dly
            logic [OUT_W-1:0] r;
            if (g == 0) begin : g_first
                // Capture the offset phase into the delay line
                always_ff @(posedge clk) begin
                    if (!rst_n) r <= '0;
                    else        r <= head;
                end
            end else begin : g_next
                // Advance one delay stage
                always_ff @(posedge clk) begin
                    if (!rst_n) r <= '0;
                    else        r <= g_dly[g-1].r;
                end
            end
        end
    endgenerate

    assign phase = g_dly[NSTG-1].r;

endmodule

// File: rtl/dds_phase_engine.sv
// NCO phase engine: register bus, pin synchronizers and accumulator.
// Assumes: pins are asynchronous; the serial word is already synchronous.
module dds_phase_engine #(
    parameter int ACC_W    = 48,
    parameter int OUT_W    = 16,
    parameter int DW       = 8,
    parameter int ADDR_W   = 4,
    parameter int SYNC_N   = 2,
    parameter int OUT_LAT  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              load_pin,
    input  logic              fsk_gate,
    input  logic [1:0]        quad_sel,
    input  logic [ACC_W-1:0]  ser_freq,
    output logic [OUT_W-1:0]  phase_word
);

    logic [3:0]       pins_s;
    logic             load_s;
    logic             fsk_s;
    logic [1:0]       quad_s;
    logic [ACC_W-1:0] base_hold, dev_hold, base_act, dev_act;
    logic             ser_on;
    logic             load_any;

    dds_pin_sync #(.WIDTH(4), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({load_pin, fsk_gate, quad_sel}),
        .q     (pins_s)
    );

    assign load_s = pins_s[3];
    assign fsk_s  = pins_s[2];
    assign quad_s = pins_s[1:0];

    dds_freq_regs #(.ACC_W(ACC_W), .DW(DW), .AW(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .load_s    (load_s),
        .base_hold (base_hold),
        .dev_hold  (dev_hold),
        .base_act  (base_act),
        .dev_act   (dev_act),
        .ser_on    (ser_on),
        .load_any  (load_any)
    );

    dds_phase_acc #(.ACC_W(ACC_W), .OUT_W(OUT_W), .LAT(OUT_LAT)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .base   (base_act),
        .dev    (dev_act),
        .ser    (ser_freq),
        .dev_on (fsk_s),
        .ser_on (ser_on),
        .quad   (quad_s),
        .phase  (phase_word)
    );

endmodule

// File: rtl/dds_phase_checker.sv
// Protocol checks on the phase engine, bound into every instance.
// Assumes: the engine's default address map (ignored 12 and 14, load at 15).
module dds_phase_checker #(
    parameter int ACC_W = 48,
    parameter int AW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic             fsk_gate,
    input logic             fsk_s,
    input logic [ACC_W-1:0] base_hold,
    input logic [ACC_W-1:0] dev_hold,
    input logic [ACC_W-1:0] base_act,
    input logic [ACC_W-1:0] dev_act,
    input logic             ser_on,
    input logic             load_any
);

    logic [1:0] since;

    // Count edges since reset release, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)               since <= 2'd0;
        else if (since != 2'd3)   since <= since + 2'd1;
    end

    a_r6_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load_any |=> $stable(base_act) && $stable(dev_act))
        else $error("R6: active word changed without a load");

    a_r11_first_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (since == 2'd0) |=> $stable(base_hold) && $stable(dev_hold) && $stable(ser_on))
        else $error("R11: write taken on first edge after release");

    a_r12_ignored_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (since != 2'd0 && wr_en && (wr_addr == AW'(12) || wr_addr == AW'(14)) && !load_any)
        |=> $stable(base_hold) && $stable(dev_hold) && $stable(base_act)
            && $stable(dev_act) && $stable(ser_on))
        else $error("R12: ignored address changed state");

    a_r8_reg_load: assert property (@(posedge clk) disable iff (!rst_n)
        (since != 2'd0 && wr_en && wr_addr == AW'(15))
        |=> base_act == $past(base_hold) && dev_act == $past(dev_hold))
        else $error("R8: load by register write failed");

    a_r10_gate_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 2'd2) |-> fsk_s == $past(fsk_gate, 2))
        else $error("R10: gate synchronizer delay wrong");

endmodule

bind dds_phase_engine dds_phase_checker #(.ACC_W(ACC_W), .AW(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .fsk_gate  (fsk_gate),
    .fsk_s     (fsk_s),
    .base_hold (base_hold),
    .dev_hold  (dev_hold),
    .base_act  (base_act),
    .dev_act   (dev_act),
    .ser_on    (ser_on),
    .load_any  (load_any)
);

// File: tb/sim_dds_phase_engine.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks at computed cycles.
module sim_dds_phase_engine;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        load_pin = 1'b0;
    logic        fsk_gate = 1'b0;
    logic [1:0]  quad_sel = 2'b00;
    logic [47:0] ser_freq = '0;
    logic [15:0] phase_word;

    dds_phase_engine u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .load_pin   (load_pin),
        .fsk_gate   (fsk_gate),
        .quad_sel   (quad_sel),
        .ser_freq   (ser_freq),
        .phase_word (phase_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    bit    m_valid = 0;
    string tag = "R1";

    // Reference model state
    logic [47:0] m_acc, m_bh, m_dh, m_ba, m_da, m_step;
    logic        m_ser, m_wok, m_ld;
    logic [1:0]  m_lds, m_fss;
    logic [1:0]  m_q1, m_q2;
    logic [15:0] dq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = '0; m_bh = 48'h1 << 46; m_ba = 48'h1 << 46;
            m_dh = '0; m_da = '0; m_ser = 1'b1; m_wok = 1'b0;
            m_lds = '0; m_fss = '0; m_q1 = '0; m_q2 = '0;
            dq = {};
            for (int i = 0; i < 10; i++) dq.push_back(16'h0);
            m_valid = 1;
        end else begin
            m_ld   = m_lds[1] || (m_wok && wr_en && wr_addr == 4'd15);
            m_step = m_ba + (m_fss[1] ? m_da : 48'h0) + (m_ser ? ser_freq : 48'h0);
            dq.push_back(m_acc[47:32] + {m_q2, 14'h0});
            void'(dq.pop_front());
            m_acc = m_acc + m_step;
            if (m_ld) begin m_ba = m_bh; m_da = m_dh; end
            if (m_wok && wr_en) begin
                if (wr_addr < 4'd6)        m_bh[int'(wr_addr)*8 +: 8] = wr_data;
                else if (wr_addr < 4'd12)  m_dh[(int'(wr_addr)-6)*8 +: 8] = wr_data;
                else if (wr_addr == 4'd13) m_ser = wr_data[6];
            end
            m_wok = 1'b1;
            m_lds = {m_lds[0], load_pin};
            m_fss = {m_fss[0], fsk_gate};
            m_q2  = m_q1;
            m_q1  = quad_sel;
        end
    end

    // Compare against the model away from the active edge
    always @(negedge clk) begin
        if (m_valid && !done) begin
            n_cmp++;
            if (phase_word !== dq[0]) begin
                n_bad++;
                $display("FAIL %s: phase_word actual %h expected %h at %0t",
                         tag, phase_word, dq[0], $time);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_word(input logic [3:0] base, input logic [47:0] v);
        for (int b = 0; b < 6; b++) wr(base + 4'(b), v[b*8 +: 8]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [15:0] a, b;
        ticks(3);
        chk(phase_word == 16'h0, "R1 reset output", phase_word, 16'h0);
        // R11: release with a write present on the first edge
        rst_n = 1'b1; wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'hAB; tag = "R11";
        @(negedge clk); wr_en = 1'b0;
        ticks(9);
        chk(phase_word == 16'h0, "R2 latency edge 10", phase_word, 16'h0);
        ticks(1);
        chk(phase_word == 16'h4000, "R1 first advance edge 11", phase_word, 16'h4000);
        ticks(1);
        chk(phase_word == 16'h8000, "R1 second advance", phase_word, 16'h8000);
        wr(4'd15, 8'h00);
        ticks(13);
        a = phase_word; ticks(1); b = phase_word;
        chk(b - a == 16'h4000, "R11 dropped write", b - a, 16'h4000);

        tag = "R6";
        wr_word(4'd0, 48'h0123_4567_89AB);
        ticks(12);
        a = phase_word; ticks(1); b = phase_word;
        chk(b - a == 16'h4000, "R6 hold until load", b - a, 16'h4000);

        tag = "R7";
        load_pin = 1'b1; ticks(1); load_pin = 1'b0;
        ticks(16);
        a = phase_word; ticks(1); b = phase_word;
        chk(b - a == 16'h0123, "R7 pin load step", b - a, 16'h0123);

        tag = "R10";
        wr_word(4'd0, 48'h2000_0000_0000);
        load_pin = 1'b1; ticks(3); load_pin = 1'b0;
        ticks(14);

        tag = "R8";
        wr_word(4'd6, 48'h0100_0000_0000);
        fsk_gate = 1'b1;
        wr(4'd15, 8'h5A);
        ticks(14);
        a = phase_word; ticks(1); b = phase_word;
        chk(b - a == 16'h2100, "R8 register load", b - a, 16'h2100);

        tag = "R4";
        for (int k = 0; k < 8; k++) begin
            fsk_gate = ~fsk_gate; ticks(3);
        end
        fsk_gate = 1'b0; ticks(14);
        a = phase_word; ticks(1); b = phase_word;
        chk(b - a == 16'h2000, "R4 gate low", b - a, 16'h2000);

        tag = "R5";
        ser_freq = 48'h0030_0000_0000;
        ticks(14);
        wr(4'd13, 8'hBF);
        ticks(14);
        a = phase_word; ticks(1); b = phase_word;
        chk(b - a == 16'h2000, "R5 serial removed", b - a, 16'h2000);
        wr(4'd13, 8'h40);
        ticks(14);
        a = phase_word; ticks(1); b = phase_word;
        chk(b - a == 16'h2030, "R5 serial restored", b - a, 16'h2030);

        tag = "R9";
        for (int q = 0; q < 4; q++) begin
            quad_sel = 2'(q); ticks(14);
        end
        quad_sel = 2'b00; ticks(12);

        tag = "R12";
        wr(4'd12, 8'hFF); wr(4'd14, 8'h30); wr(4'd12, 8'h00);
        ticks(14);
        a = phase_word; ticks(1); b = phase_word;
        chk(b - a == 16'h2030, "R12 ignored addresses", b - a, 16'h2030);

        tag = "R3";
        fsk_gate = 1'b1;
        wr_word(4'd0, 48'hFFFF_FFFF_FFFF);
        wr_word(4'd6, 48'h0000_0000_0001);
        wr(4'd13, 8'h00);
        wr(4'd15, 8'h00);
        ticks(16);
        a = phase_word; ticks(1); b = phase_word;
        chk(b == a, "R3 wrap freezes phase", b, a);

        tag = "R1";
        fsk_gate = 1'b0; ser_freq = '0; quad_sel = 2'b00;
        rst_n = 1'b0; ticks(2);
        chk(phase_word == 16'h0, "R1 mid-run reset", phase_word, 16'h0);
        rst_n = 1'b1; tag = "R2";
        ticks(11);
        chk(phase_word == 16'h4000, "R2 restart latency", phase_word, 16'h4000);
        ticks(4);
        finish_run();
    end

endmodule